// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches the already-synchronized input pins of one GPIO bank and turns selected conditions on each pin into latched status bits. Every pin can detect a level (active high or active low), a single edge (rising or falling), or both edges. Each pin has its own type, polarity and any-edge bits, written one full word at a time.

Software unmasks pins by writing ones to an enable port and masks them by writing ones to a disable port. The resulting mask word can be read but not written directly. Status bits are cleared by writing ones. Detection keeps running while a pin is masked. A status bit caught while masked therefore raises the request as soon as the pin is unmasked, unless it was cleared first. A single registered request output tells an upstream interrupt controller that some unmasked status bit is set.

All writes use one port: a strobe, a 3-bit selector and a data word. Configuration, mask and status come out as plain read words.

Top module: `gpio_pin_irq`

## Requirements
- R1: While reset is asserted and right after it, every mask bit reads 1, every status bit reads 0, the type, polarity and any-edge words read 0, and the request output is 0.
- R2: A write with selector 0 loads the type word, selector 1 loads the polarity word and selector 2 loads the any-edge word. Each is visible on its read output after the write's clock edge.
- R3: A pin whose type bit is 1 and any-edge bit is 0 sets its status bit on a rising edge when its polarity bit is 1, and on a falling edge when its polarity bit is 0. The opposite edge and a steady level do not set it.
- R4: A pin whose type bit is 1 and any-edge bit is 1 sets its status bit on either edge, whatever its polarity bit.
- R5: A pin whose type bit is 0 sets its status bit while the pin equals its polarity bit (1 = active high, 0 = active low). The any-edge bit has no effect.
- R6: A write with selector 3 clears the mask bits where the data is 1, and a write with selector 4 sets them. Data bits of 0 leave the mask unchanged, and writing all ones with selector 4 masks every pin.
- R7: A write with selector 5 clears the status bits where the data is 1. Status bits written 0, and status bits with no write, stay set.
- R8: Detection and status latching continue while a pin is masked. A status bit latched while masked raises the request after the pin is unmasked. If the bit is cleared before unmasking, the request stays low.
- R9: For a level-type pin whose level stays active, a clear makes its status bit read 0 for exactly one cycle. The bit reads 1 again on the next clock.
- R10: An edge detected in the same cycle as a clear of that pin's status bit leaves the bit set.
- R11: The request output equals the OR over all pins of (status AND NOT mask), delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | NPIN | Synchronized pin levels |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 3 | Write target: 0 type, 1 polarity, 2 any-edge, 3 unmask, 4 mask, 5 status clear |
| wr_data_i | input | NPIN | Write data, one bit per pin |
| type_o | output | NPIN | Type word (1 edge, 0 level) |
| pol_o | output | NPIN | Polarity word |
| any_o | output | NPIN | Any-edge word |
| mask_o | output | NPIN | Mask word (1 = masked) |
| status_o | output | NPIN | Latched status word |
| irq_o | output | 1 | Combined registered interrupt request |

## Verification
The bench walks every combination of type, polarity and any-edge against held levels, rises and falls. A decoder with swapped polarity or a live any-edge bit in level mode would latch the wrong pins.

Directed cases cover the following:
- A stale status bit caught while masked, then unmasked. A design that gated detection with the mask would never raise the request.
- The same bit cleared before unmasking. A design that ignores the clear would raise a spurious request.
- A level clear that reasserts after one cycle, and an edge arriving together with a clear. Wrong priority either hides the clear or loses the edge.

The mask ports are written with partial words, so a design that treats 0 bits as writes would disturb other pins. The one-cycle lag of the request is checked on both its rise and its fall.

// File: rtl/gpio_pin_irq_pkg.sv
package gpio_pin_irq_pkg;

    typedef enum logic [2:0] {
        SEL_TYPE   = 3'd0,
        SEL_POL    = 3'd1,
        SEL_ANY    = 3'd2,
        SEL_UNMASK = 3'd3,
        SEL_MASK   = 3'd4,
        SEL_CLEAR  = 3'd5
    } wr_sel_e;

endpackage

// File: rtl/gpio_pin_irq_cfg.sv
module gpio_pin_irq_cfg
    import gpio_pin_irq_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en_i,
    input  logic [2:0]      wr_sel_i,
    input  logic [NPIN-1:0] wr_data_i,
    output logic [NPIN-1:0] type_o,
    output logic [NPIN-1:0] pol_o,
    output logic [NPIN-1:0] any_o,
    output logic [NPIN-1:0] mask_o
);

    typedef struct packed {
        logic [NPIN-1:0] typ;
        logic [NPIN-1:0] pol;
        logic [NPIN-1:0] any;
        logic [NPIN-1:0] mask;
    } cfg_t;

    localparam logic [NPIN-1:0] ALL_ONES = {NPIN{1'b1}};

    cfg_t    cfg_d, cfg_q;
    wr_sel_e sel;

    assign sel = wr_sel_e'(wr_sel_i);

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            case (sel)
                SEL_TYPE:   cfg_d.typ  = wr_data_i;
                SEL_POL:    cfg_d.pol  = wr_data_i;
                SEL_ANY:    cfg_d.any  = wr_data_i;
                SEL_UNMASK: cfg_d.mask = cfg_q.mask & ~wr_data_i;
                SEL_MASK:   cfg_d.mask = cfg_q.mask | wr_data_i;
                default:    cfg_d      = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.typ  <= '0;
            cfg_q.pol  <= '0;
            cfg_q.any  <= '0;
            cfg_q.mask <= ALL_ONES;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign type_o = cfg_q.typ;
    assign pol_o  = cfg_q.pol;
    assign any_o  = cfg_q.any;
    assign mask_o = cfg_q.mask;

endmodule

// File: rtl/gpio_pin_irq_detect.sv
module gpio_pin_irq_detect #(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_i,
    input  logic [NPIN-1:0] type_i,
    input  logic [NPIN-1:0] pol_i,
    input  logic [NPIN-1:0] any_i,
    input  logic [NPIN-1:0] clear_i,
    output logic [NPIN-1:0] status_o
);

    typedef struct packed {
        logic [NPIN-1:0] prev;
        logic [NPIN-1:0] status;
    } det_t;

    det_t            det_d, det_q;
    logic [NPIN-1:0] edge_hit;
    logic [NPIN-1:0] level_hit;

    // Per-pin condition decode
    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        logic rise, fall;
        assign rise = pin_i[g] & ~det_q.prev[g];
        assign fall = ~pin_i[g] & det_q.prev[g];
        always_comb begin
            edge_hit[g]  = 1'b0;
            level_hit[g] = 1'b0;
            if (type_i[g]) begin
                if (any_i[g])      edge_hit[g] = rise | fall;
                else if (pol_i[g]) edge_hit[g] = rise;
                else               edge_hit[g] = fall;
            end else begin
                level_hit[g] = (pin_i[g] == pol_i[g]);
            end
        end
    end

    // Edges win over a clear; a held level is dropped for the clear cycle
    always_comb begin
        det_d.prev   = pin_i;
        det_d.status = (det_q.status & ~clear_i) | edge_hit | (level_hit & ~clear_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q <= '0;
        end else begin
            det_q <= det_d;
        end
    end

    assign status_o = det_q.status;

endmodule

// File: rtl/gpio_pin_irq_merge.sv
module gpio_pin_irq_merge #(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] status_i,
    input  logic [NPIN-1:0] mask_i,
    output logic            irq_o
);

    logic irq_d, irq_q;

    always_comb begin
        irq_d = |(status_i & ~mask_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/gpio_pin_irq.sv
module gpio_pin_irq
    import gpio_pin_irq_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_i,
    input  logic            wr_en_i,
    input  logic [2:0]      wr_sel_i,
    input  logic [NPIN-1:0] wr_data_i,
    output logic [NPIN-1:0] type_o,
    output logic [NPIN-1:0] pol_o,
    output logic [NPIN-1:0] any_o,
    output logic [NPIN-1:0] mask_o,
    output logic [NPIN-1:0] status_o,
    output logic            irq_o
);

    logic [NPIN-1:0] clear_bits;

    assign clear_bits = (wr_en_i && wr_sel_i == SEL_CLEAR) ? wr_data_i : '0;

    gpio_pin_irq_cfg #(.NPIN(NPIN)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .type_o    (type_o),
        .pol_o     (pol_o),
        .any_o     (any_o),
        .mask_o    (mask_o)
    );

    gpio_pin_irq_detect #(.NPIN(NPIN)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_i    (pin_i),
        .type_i   (type_o),
        .pol_i    (pol_o),
        .any_i    (any_o),
        .clear_i  (clear_bits),
        .status_o (status_o)
    );

    gpio_pin_irq_merge #(.NPIN(NPIN)) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status_o),
        .mask_i   (mask_o),
        .irq_o    (irq_o)
    );

endmodule

// File: rtl/gpio_pin_irq_chk.sv
module gpio_pin_irq_chk
    import gpio_pin_irq_pkg::*;
#(
    parameter int NPIN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en_i,
    input logic [2:0]      wr_sel_i,
    input logic [NPIN-1:0] wr_data_i,
    input logic [NPIN-1:0] mask_o,
    input logic [NPIN-1:0] status_o,
    input logic            irq_o
);

    AST_IRQ_LAGS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_o == $past(|(status_o & ~mask_o)));                           // R11

    AST_UNMASK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == SEL_UNMASK) |=> (mask_o & $past(wr_data_i)) == '0);  // R6

    AST_MASK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == SEL_MASK) |=> (mask_o & $past(wr_data_i)) == $past(wr_data_i)); // R6

    AST_MASK_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(mask_o));                                              // R6

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && wr_sel_i == SEL_CLEAR) |=> ($past(status_o) & ~status_o) == '0); // R7

endmodule

bind gpio_pin_irq gpio_pin_irq_chk #(.NPIN(NPIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .mask_o    (mask_o),
    .status_o  (status_o),
    .irq_o     (irq_o)
);

// File: tb/gpio_pin_irq_tb.sv
`timescale 1ns/1ps
module gpio_pin_irq_tb;

    localparam int NPIN = 32;
    localparam logic [NPIN-1:0] ONES = {NPIN{1'b1}};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NPIN-1:0] pin_i = '0;
    logic            wr_en_i = 1'b0;
    logic [2:0]      wr_sel_i = '0;
    logic [NPIN-1:0] wr_data_i = '0;
    logic [NPIN-1:0] type_o, pol_o, any_o, mask_o, status_o;
    logic            irq_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    gpio_pin_irq #(.NPIN(NPIN)) u_dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en_i(wr_en_i),
        .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .type_o(type_o),
        .pol_o(pol_o), .any_o(any_o), .mask_o(mask_o),
        .status_o(status_o), .irq_o(irq_o)
    );

    // {type, pol, any, level_before, level_after, expected_status}
    localparam logic [5:0] VECS [0:13] = '{
        6'b110_01_1, // R3 rising seen
        6'b110_10_0, // R3 falling ignored under rising
        6'b110_11_0, // R3 steady high no edge
        6'b100_10_1, // R3 falling seen
        6'b100_01_0, // R3 rising ignored under falling
        6'b101_01_1, // R4 any-edge rise, pol 0
        6'b111_10_1, // R4 any-edge fall, pol 1
        6'b111_00_0, // R4 no edge
        6'b010_01_1, // R5 level high active
        6'b011_00_0, // R5 level high inactive, any ignored
        6'b011_11_1, // R5 any ignored when active
        6'b000_10_1, // R5 level low active
        6'b001_11_0, // R5 level low inactive
        6'b000_00_1  // R5 level low held
    };

    task automatic check(input string req, input logic [NPIN-1:0] act, input logic [NPIN-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [NPIN-1:0] data);
        wr_en_i   = 1'b1;
        wr_sel_i  = sel;
        wr_data_i = data;
        @(negedge clk);
        wr_en_i   = 1'b0;
        wr_data_i = '0;
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #200000;
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        step(3);
        check("R1 mask", mask_o, ONES);
        check("R1 status", status_o, '0);
        check("R1 cfg", type_o | pol_o | any_o, '0);
        check("R1 irq", {31'b0, irq_o}, '0);
        rst_n = 1'b1;
        step(1);
        check("R1 mask after release", mask_o, ONES);

        // Table walk over detection modes
        for (int i = 0; i < 14; i++) begin
            wr(3'd0, {NPIN{VECS[i][5]}});
            wr(3'd1, {NPIN{VECS[i][4]}});
            wr(3'd2, {NPIN{VECS[i][3]}});
            pin_i = {NPIN{VECS[i][2]}};
            step(2);
            wr(3'd5, ONES);
            pin_i = {NPIN{VECS[i][1]}};
            step(1);
            check($sformatf("R3/R4/R5 vector %0d", i), status_o, {NPIN{VECS[i][0]}});
        end

        // R2 readback
        wr(3'd0, 32'hA5A5_0F0F);
        wr(3'd1, 32'h1234_5678);
        wr(3'd2, 32'h8000_0001);
        check("R2 type", type_o, 32'hA5A5_0F0F);
        check("R2 pol", pol_o, 32'h1234_5678);
        check("R2 any", any_o, 32'h8000_0001);

        // R6 partial mask writes
        wr(3'd4, ONES);
        wr(3'd3, 32'h5);
        check("R6 unmask", mask_o, ~32'h5);
        wr(3'd4, 32'h1);
        check("R6 mask", mask_o, ~32'h4);
        wr(3'd4, ONES);
        check("R6 mask all", mask_o, ONES);

        // R8 stale status raises request on unmask; R11 lag
        wr(3'd0, '0);
        wr(3'd1, ONES);
        wr(3'd2, '0);
        pin_i = '0;
        step(1);
        wr(3'd5, ONES);
        pin_i[3] = 1'b1;
        step(1);
        pin_i[3] = 1'b0;
        step(2);
        check("R8 latched while masked", status_o, 32'h8);
        check("R8 masked irq low", {31'b0, irq_o}, '0);
        wr(3'd3, 32'h8);
        check("R11 irq lags unmask", {31'b0, irq_o}, '0);
        step(1);
        check("R8 irq after unmask", {31'b0, irq_o}, 32'h1);
        wr(3'd5, 32'h0);
        check("R7 zero clear keeps status", status_o, 32'h8);
        wr(3'd5, 32'h8);
        check("R7 cleared", status_o, '0);
        check("R11 irq lags clear", {31'b0, irq_o}, 32'h1);
        step(1);
        check("R11 irq falls", {31'b0, irq_o}, '0);

        // R8 clear before unmask keeps request low
        pin_i[4] = 1'b1;
        step(1);
        pin_i[4] = 1'b0;
        step(1);
        wr(3'd5, 32'h10);
        wr(3'd3, 32'h10);
        step(2);
        check("R8 cleared then unmasked", {31'b0, irq_o}, '0);

        // R9 level clear reasserts
        pin_i[5] = 1'b1;
        step(1);
        check("R9 set", status_o & 32'h20, 32'h20);
        wr(3'd5, 32'h20);
        check("R9 low one cycle", status_o & 32'h20, '0);
        step(1);
        check("R9 reasserted", status_o & 32'h20, 32'h20);
        pin_i[5] = 1'b0;

        // R10 edge together with clear
        wr(3'd0, ONES);
        wr(3'd1, ONES);
        wr(3'd2, '0);
        step(2);
        wr(3'd5, ONES);
        wr_en_i = 1'b1; wr_sel_i = 3'd5; wr_data_i = ONES;
        pin_i[6] = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; wr_data_i = '0;
        check("R10 edge beats clear", status_o, 32'h40);

        // R6 all-ones disable drops request
        wr(3'd3, 32'h40);
        step(1);
        check("R11 irq up", {31'b0, irq_o}, 32'h1);
        wr(3'd4, ONES);
        step(1);
        check("R6 all masked irq low", {31'b0, irq_o}, '0);
        check("R6 all masked", mask_o, ONES);

        finish_run();
    end

endmodule